// File: doc/BRIEF.md
# Programmable Counter Time Base

This block is a time base built from a prescaler, a counter and a reload limit. The prescaler divides the input clock by a programmable ratio. Each resulting tick moves the counter one step. When the counter reaches the end of its range, the block raises an update event. The counter can count upward, count downward, or sweep up and then down (center-aligned), and a status bit reports the current direction.

Software reaches every setting through a small register port: a write strobe, an address and write data, with read data returned combinationally for the current address. This works while the counter runs. The prescale ratio and, when the preload option is on, the reload limit are held in shadow registers. They reach the working copies only at an update event. An update can also be forced from software, which restarts the count and the prescaler from a clean point.

Each update event produces a one-cycle pulse and sets a sticky flag that software clears.

Top module: `tbu_timebase`

## Requirements
- R1: After reset the count, the update pulse and the flag read 0, the direction reads 0 (up), the control register (address 0) reads 0, the prescale register (address 3) reads 0 and the limit register (address 4) reads all ones.
- R2: With prescale value P, the counter steps once every P+1 clock cycles.
- R3: In up mode (control bits [2:1] = 0), the counter steps from 0 to the limit L, then returns to 0 with an update event, so events are (L+1)*(P+1) cycles apart.
- R4: In down mode (bits [2:1] = 1), the counter steps from L to 0, then reloads L with an update event, with the same spacing as up mode.
- R5: In center mode (bits [2:1] = 2), the counter climbs from 0 and on reaching L raises an event and turns downward. It falls to 0, raises an event and turns upward. Events are L*(P+1) cycles apart, and the direction output (also control bit 5 on read) is 1 while counting down.
- R6: A write to the prescale register (address 3) changes the division ratio only from the next update event onward. The register reads back the written value at once.
- R7: With the preload bit (control bit 3) clear, a write to the limit register (address 4) takes effect immediately. With it set, the new limit takes effect from the next update event.
- R8: Writing control with bit 4 set forces an update event. The count restarts at 0 (up and center modes, direction up) or at the limit (down mode), the prescaler restarts, and the shadow values load. Bit 4 reads 0.
- R9: Every update event sets the sticky flag (address 1 bit 0). Writing 0 to that bit clears it, and writing 1 leaves it unchanged. An event in the same cycle wins over a clear.
- R10: The count reads and writes at address 2. While control bit 0 (run) is 0, the count holds its value.
- R11: Each update event produces exactly one single-cycle pulse on the update output. No pulse appears without an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Read data for reg_addr |
| cnt_o | output | CNT_W | Current count |
| dir_o | output | 1 | 1 while counting down |
| upd_o | output | 1 | One-cycle update event pulse |
| uif_o | output | 1 | Sticky update flag |

## Verification
The bench builds the block with a 16-bit counter and a 16-bit prescaler. This makes the all-ones reset value of the limit observable in full. The bench then programs small limits (2 to 9) and prescale values (0 to 3), which keeps each period within a few dozen cycles. That brings several event spacings per mode within reach, together with the change of spacing exactly one event after a shadowed write, in a short run.

// File: rtl/tbu_pkg.sv
package tbu_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2,
        MODE_RSVD   = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic      arpe;
        cnt_mode_e mode;
        logic      run;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd2;
    localparam logic [ADDR_W-1:0] A_PSC  = 3'd3;
    localparam logic [ADDR_W-1:0] A_ARR  = 3'd4;

    localparam int B_RUN   = 0;
    localparam int B_MODE  = 1;
    localparam int B_ARPE  = 3;
    localparam int B_FORCE = 4;
    localparam int B_DIR   = 5;
endpackage

// File: rtl/tbu_regs.sv
module tbu_regs
    import tbu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [CNT_W-1:0]  wdata,
    input  logic              evt,
    output ctrl_t             ctrl,
    output logic [PSC_W-1:0]  psc_pre,
    output logic [CNT_W-1:0]  arr_pre,
    output logic              uif,
    output logic              force_upd,
    output logic              cnt_wr,
    output logic              arr_wr
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] arr;
        logic             uif;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && addr == A_CTRL) begin
            st_d.ctrl.run  = wdata[B_RUN];
            st_d.ctrl.mode = cnt_mode_e'(wdata[B_MODE +: 2]);
            st_d.ctrl.arpe = wdata[B_ARPE];
        end
        if (wr && addr == A_PSC) st_d.psc = wdata[PSC_W-1:0];
        if (wr && addr == A_ARR) st_d.arr = wdata;
        if (wr && addr == A_STAT && !wdata[0]) st_d.uif = 1'b0;
        if (evt) st_d.uif = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.arr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl      = st_q.ctrl;
    assign psc_pre   = st_q.psc;
    assign arr_pre   = st_q.arr;
    assign uif       = st_q.uif;
    assign force_upd = wr && addr == A_CTRL && wdata[B_FORCE];
    assign cnt_wr    = wr && addr == A_CNT;
    assign arr_wr    = wr && addr == A_ARR;
endmodule

// File: rtl/tbu_prescaler.sv
module tbu_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             evt,
    input  logic [PSC_W-1:0] psc_pre,
    output logic             tick
);
    typedef struct packed {
        logic [PSC_W-1:0] pcnt;
        logic [PSC_W-1:0] act;
    } state_t;

    state_t st_d, st_q;

    assign tick = run && (st_q.pcnt == st_q.act);

    always_comb begin
        st_d = st_q;
        if (evt) begin
            st_d.pcnt = '0;
            st_d.act  = psc_pre;
        end else if (tick) begin
            st_d.pcnt = '0;
        end else if (run) begin
            st_d.pcnt = st_q.pcnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tbu_counter.sv
module tbu_counter
    import tbu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             tick,
    input  logic             force_upd,
    input  logic             cnt_wr,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] arr_pre,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] arr_act,
    output logic             dir_down,
    output logic             evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] arr;
        logic             dir;
    } state_t;

    state_t st_d, st_q;
    logic hit;
    logic [CNT_W:0] nxt_up;

    assign nxt_up = {1'b0, st_q.cnt} + 1'b1;

    always_comb begin
        unique case (ctrl.mode)
            MODE_DOWN:   hit = (st_q.cnt == '0);
            MODE_CENTER: hit = st_q.dir ? (st_q.cnt <= CNT_W'(1))
                                        : (nxt_up >= {1'b0, st_q.arr});
            default:     hit = (st_q.cnt >= st_q.arr);
        endcase
    end

    assign evt = force_upd | (tick & ~cnt_wr & hit);

    always_comb begin
        st_d = st_q;
        if (evt) st_d.arr = arr_pre;
        if (arr_wr && !ctrl.arpe) st_d.arr = wdata;
        if (force_upd) begin
            st_d.cnt = (ctrl.mode == MODE_DOWN) ? arr_pre : '0;
            st_d.dir = (ctrl.mode == MODE_DOWN);
        end else if (cnt_wr) begin
            st_d.cnt = wdata;
        end else if (tick) begin
            unique case (ctrl.mode)
                MODE_DOWN: st_d.cnt = hit ? arr_pre : st_q.cnt - 1'b1;
                MODE_CENTER: begin
                    if (!st_q.dir) begin
                        if (hit) begin
                            st_d.cnt = st_q.arr;
                            st_d.dir = 1'b1;
                        end else begin
                            st_d.cnt = st_q.cnt + 1'b1;
                        end
                    end else begin
                        if (hit) begin
                            st_d.cnt = '0;
                            st_d.dir = 1'b0;
                        end else begin
                            st_d.cnt = st_q.cnt - 1'b1;
                        end
                    end
                end
                default: st_d.cnt = hit ? '0 : st_q.cnt + 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.arr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt      = st_q.cnt;
    assign arr_act  = st_q.arr;
    assign dir_down = (ctrl.mode == MODE_DOWN) | ((ctrl.mode == MODE_CENTER) & st_q.dir);
endmodule

// File: rtl/tbu_timebase.sv
module tbu_timebase
    import tbu_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              dir_o,
    output logic              upd_o,
    output logic              uif_o
);
    ctrl_t            ctrl_w;
    logic [PSC_W-1:0] psc_pre_w;
    logic [CNT_W-1:0] arr_pre_w;
    logic [CNT_W-1:0] arr_act_w;
    logic             force_w;
    logic             cnt_wr_w;
    logic             arr_wr_w;
    logic             tick_w;
    logic             evt_w;
    logic             upd_d, upd_q;

    tbu_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .evt(evt_w), .ctrl(ctrl_w), .psc_pre(psc_pre_w), .arr_pre(arr_pre_w),
        .uif(uif_o), .force_upd(force_w), .cnt_wr(cnt_wr_w), .arr_wr(arr_wr_w)
    );

    tbu_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(ctrl_w.run), .evt(evt_w),
        .psc_pre(psc_pre_w), .tick(tick_w)
    );

    tbu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl_w), .tick(tick_w), .force_upd(force_w),
        .cnt_wr(cnt_wr_w), .arr_wr(arr_wr_w), .wdata(reg_wdata), .arr_pre(arr_pre_w),
        .cnt(cnt_o), .arr_act(arr_act_w), .dir_down(dir_o), .evt(evt_w)
    );

    always_comb upd_d = evt_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) upd_q <= 1'b0;
        else        upd_q <= upd_d;
    end

    assign upd_o = upd_q;

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[B_RUN]        = ctrl_w.run;
                reg_rdata[B_MODE +: 2]  = ctrl_w.mode;
                reg_rdata[B_ARPE]       = ctrl_w.arpe;
                reg_rdata[B_DIR]        = dir_o;
            end
            A_STAT:  reg_rdata[0] = uif_o;
            A_CNT:   reg_rdata = cnt_o;
            A_PSC:   reg_rdata = CNT_W'(psc_pre_w);
            A_ARR:   reg_rdata = arr_pre_w;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tbu_timebase_chk.sv
module tbu_timebase_chk
    import tbu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt,
    input ctrl_t             ctrl,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  arr_act,
    input logic              cnt_wr,
    input logic              force_upd,
    input logic              uif,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CNT_W-1:0]  reg_wdata
);
    p_up_wraps_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && ctrl.mode == MODE_UP) |=> (cnt == '0));

    p_down_reloads_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && ctrl.mode == MODE_DOWN) |=> (cnt == arr_act));

    p_stopped_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !cnt_wr && !force_upd) |=> $stable(cnt));

    p_event_sets_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> uif);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uif && !(reg_wr && reg_addr == A_STAT && !reg_wdata[0])) |=> uif);
endmodule

bind tbu_timebase tbu_timebase_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .evt(evt_w), .ctrl(ctrl_w), .cnt(cnt_o),
    .arr_act(arr_act_w), .cnt_wr(cnt_wr_w), .force_upd(force_w), .uif(uif_o),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/tb_tbu_timebase.sv
`timescale 1ns/1ps
module tb_tbu_timebase;
    import tbu_pkg::*;
    localparam int CNT_W = 16;
    localparam int PSC_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [CNT_W-1:0]  reg_wdata = '0;
    logic [CNT_W-1:0]  reg_rdata;
    logic [CNT_W-1:0]  cnt_o;
    logic              dir_o, upd_o, uif_o;

    always #2 clk = ~clk;

    tbu_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_o(cnt_o),
        .dir_o(dir_o), .upd_o(upd_o), .uif_o(uif_o)
    );

    int checks = 0;
    int fails  = 0;

    typedef struct {
        int    gap;
        int    cnt;
        bit    dir;
        string req;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;
    int   cyc = 0;
    int   last_cyc = 0;

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(int gap, int cnt, bit dir, string req);
        exp_t e;
        e.gap = gap; e.cnt = cnt; e.dir = dir; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic reg_write(logic [ADDR_W-1:0] a, int d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = CNT_W'(d);
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(logic [ADDR_W-1:0] a, output int v);
        @(negedge clk);
        reg_addr = a;
        reg_wr   = 1'b0;
        #1;
        v = int'(reg_rdata);
    endtask

    // Scoreboard monitor: each update pulse pops one expected event
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (upd_o) begin
                if (exp_q.size() == 0) begin
                    check("R11", "unexpected update pulse", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    if (cur.gap >= 0) check(cur.req, "event spacing", cyc - last_cyc, cur.gap);
                    check(cur.req, "count at event", int'(cnt_o), cur.cnt);
                    check(cur.req, "direction at event", int'(dir_o), int'(cur.dir));
                end
                last_cyc = cyc;
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int v, v2;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "count", int'(cnt_o), 0);
        check("R1", "pulse", int'(upd_o), 0);
        check("R1", "flag", int'(uif_o), 0);
        check("R1", "direction", int'(dir_o), 0);
        reg_read(A_CTRL, v); check("R1", "control", v, 0);
        reg_read(A_PSC, v);  check("R1", "prescale", v, 0);
        reg_read(A_ARR, v);  check("R1", "limit", v, 16'hFFFF);

        // R2/R3/R8: up mode, limit 9, prescale 1
        reg_write(A_ARR, 9);
        reg_write(A_PSC, 1);
        push(-1, 0, 1'b0, "R8");
        reg_write(A_CTRL, 16);
        reg_read(A_CTRL, v); check("R8", "force bit reads zero", v & 16, 0);
        push(-1, 0, 1'b0, "R3");
        push(20, 0, 1'b0, "R2");
        push(20, 0, 1'b0, "R3");
        reg_write(A_CTRL, 1);
        drain();

        // R6: new prescale only after the next event
        push(20, 0, 1'b0, "R6");
        push(40, 0, 1'b0, "R6");
        push(40, 0, 1'b0, "R6");
        reg_write(A_PSC, 3);
        reg_read(A_PSC, v); check("R6", "prescale read back", v, 3);
        drain();

        // R7: immediate limit change with preload off
        push(12, 0, 1'b0, "R7");
        push(12, 0, 1'b0, "R7");
        reg_write(A_ARR, 2);
        drain();

        // R7: shadowed limit change with preload on
        push(12, 0, 1'b0, "R7");
        push(20, 0, 1'b0, "R7");
        push(20, 0, 1'b0, "R7");
        reg_write(A_CTRL, 9);
        reg_write(A_ARR, 4);
        drain();

        // R4: down mode, limit 5, prescale 0
        reg_write(A_CTRL, 2);
        reg_write(A_ARR, 5);
        reg_write(A_PSC, 0);
        push(-1, 5, 1'b1, "R8");
        reg_write(A_CTRL, 2 | 16);
        reg_read(A_CNT, v); check("R8", "down restart at limit", v, 5);
        push(-1, 5, 1'b1, "R4");
        push(6, 5, 1'b1, "R4");
        push(6, 5, 1'b1, "R4");
        reg_write(A_CTRL, 3);
        drain();
        reg_read(A_CTRL, v); check("R5", "direction bit in down mode", (v >> 5) & 1, 1);

        // R5: center mode, limit 4
        reg_write(A_CTRL, 4);
        reg_write(A_ARR, 4);
        push(-1, 0, 1'b0, "R8");
        reg_write(A_CTRL, 4 | 16);
        push(-1, 4, 1'b1, "R5");
        push(4, 0, 1'b0, "R5");
        push(4, 4, 1'b1, "R5");
        push(4, 0, 1'b0, "R5");
        reg_write(A_CTRL, 5);
        drain();

        // R10: stop, write and hold the count
        reg_write(A_CTRL, 4);
        reg_write(A_CNT, 3);
        reg_read(A_CNT, v);
        check("R10", "count write read back", v, 3);
        repeat (6) @(negedge clk);
        reg_read(A_CNT, v2);
        check("R10", "count holds while stopped", v2, 3);

        // R8: forced update in the middle of a run restarts the period
        push(-1, 0, 1'b0, "R3");
        reg_write(A_CTRL, 1);
        drain();
        push(-1, 0, 1'b0, "R8");
        push(5, 0, 1'b0, "R8");
        reg_write(A_CTRL, 1 | 16);
        drain();
        reg_write(A_CTRL, 0);
        @(negedge clk);
        check("R11", "pulse low after event", int'(upd_o), 0);

        // R9: sticky flag
        reg_read(A_STAT, v);  check("R9", "flag set by events", v, 1);
        reg_write(A_STAT, 1);
        reg_read(A_STAT, v);  check("R9", "writing one keeps flag", v, 1);
        reg_write(A_STAT, 0);
        reg_read(A_STAT, v);  check("R9", "writing zero clears flag", v, 0);
        check("R9", "flag port after clear", int'(uif_o), 0);

        repeat (10) @(negedge clk);
        check("R11", "no pending expected events", exp_q.size(), 0);
        finish_run();
    end
endmodule